// File: doc/BRIEF.md
# Span-Command Scanline Pixel Generator

This block builds one colour channel of a scanline without a frame buffer. A chain of pixel elements, one per pixel position, receives span commands at its head. Each command moves one element further along the chain every clock. An element whose pixel falls inside a command's span adds that command's intensity into its own 36-bit fixed-point accumulator, which has 20 fraction bits. Spans are shaded with a constant, a linear ramp or a quadratic ramp. The ramps are evaluated by forward differencing: each element inside the span hands the next element the updated intensity and first difference.

Set commands load per-element preset registers for the intensity, the first difference or the second difference. A preset replaces the value that a passing evaluate command carries at that pixel. The other commands do the following. A write-and-freeze evaluate sets a span to a value and locks it. A skip command makes the next evaluate that reaches each covered pixel leave it unchanged. A mode command chooses whether negative contributions count. A refresh command makes every element emit its 12-bit pixel in address order and then clear itself for the next scanline.

Commands are 4-bit opcodes together with a start pixel, a span length and three signed 36-bit values. After a linear-ramp evaluate the block refuses commands for one cycle, and after a quadratic-ramp evaluate for two cycles. A second refresh is held off until the first has left the chain.

Top module: `pixgen_array`

## Requirements
- R1: After reset, `cmdReady` is high for a non-refresh opcode, `pixValid` is low, and a first refresh emits zero on every pixel.
- R2: A refresh (opcode 13) accepted at clock edge E makes element k appear on `pixValid`/`pixAddr`=k/`pixData` after edge E+k+1. The element then clears its accumulator, presets and locks, so that an immediate further refresh emits zeros.
- R3: A constant evaluate (opcode 8, start x, length dx) adds I to every pixel from x to x+dx inclusive. Overlapping commands are summed, and pixels beyond the last element are not affected.
- R4: A linear evaluate (opcode 9) adds I + j·dI to pixel x+j.
- R5: A quadratic evaluate (opcode 10) adds the value of a running intensity to each pixel of the span. The running intensity starts at I and grows by the running difference, which starts at dI and grows by ddI at each pixel.
- R6: Single presets (opcodes 1, 2, 3 for I, dI, ddI) at pixel x replace the carried value there for every later evaluate until refresh. The ramp continues from the replaced value, while a constant evaluate applies the preset only at that pixel.
- R7: Periodic presets (opcodes 4, 5, 6) load pixels x, x+dx, x+2dx and so on up to the end of the chain. A dx of 0 loads pixel x only.
- R8: A write-and-freeze evaluate (opcode 7) stores I into each pixel of its span. Later evaluates of any kind leave those pixels unchanged until refresh.
- R9: A skip command (opcode 11) marks a span. The next evaluate reaching each marked pixel leaves it unchanged and clears the mark.
- R10: A mode command (opcode 12) with x bit 0 clear makes negative contributions count as zero. With x bit 0 set (the reset value), negative contributions are summed.
- R11: The pixel is bits 31:20 of the accumulator, clamped to 0 when the accumulator is negative and to 4095 when bits 34:32 are non-zero.
- R12: After accepting opcode 9, `cmdReady` is low for 1 cycle; after opcode 10, for 2 cycles. After a refresh, a further refresh sees `cmdReady` low for NUM_PE−1 cycles.
- R13: Opcode 0 and the unused opcodes 14 and 15 change no pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 4 | Opcode |
| cmdX | input | 12 | Start pixel; bit 0 is the mode for opcode 12 |
| cmdDx | input | 12 | Span length or preset stride |
| cmdI | input | 36 | Signed intensity, 20 fraction bits |
| cmdD | input | 36 | Signed first difference |
| cmdDD | input | 36 | Signed second difference |
| cmdReady | output | 1 | Command is taken this cycle when high with cmdValid |
| pixValid | output | 1 | Pixel output strobe |
| pixAddr | output | 12 | Address of the emitted pixel |
| pixData | output | 12 | Clamped pixel value |

## Verification
The scanline vectors cover several span shapes:
- a span clipped at the end of the chain, overlapping another span;
- linear and quadratic ramps that start at different pixels, which separate the per-order difference updates;
- saturating and negative sums, which separate the two clamp limits;
- a preset inside a ramp, which shows whether the ramp continues from the preset;
- periodic presets under constant and linear evaluates, which check the stride counting.

Directed sequences cover freezing, skipping and both accumulation modes, where a wrong order of lock checks changes which pixels keep their values. They also cover a half-unit slope, which shows that the fraction bits are truncated, and the refresh timing, address order and clearing. The issue stalls are timed against each opcode class.

// File: rtl/pixgen_pkg.sv
package pixgen_pkg;

  parameter int unsigned ADDR_W = 12;
  parameter int unsigned VAL_W  = 36;
  parameter int unsigned FRAC_W = 20;
  parameter int unsigned PIX_W  = 12;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_SET_I    = 4'd1,
    OP_SET_D    = 4'd2,
    OP_SET_DD   = 4'd3,
    OP_SETP_I   = 4'd4,
    OP_SETP_D   = 4'd5,
    OP_SETP_DD  = 4'd6,
    OP_EVAL_FIX = 4'd7,
    OP_EVAL_C   = 4'd8,
    OP_EVAL_L   = 4'd9,
    OP_EVAL_Q   = 4'd10,
    OP_SKIP     = 4'd11,
    OP_MODE     = 4'd12,
    OP_REFRESH  = 4'd13,
    OP_RSV14    = 4'd14,
    OP_RSV15    = 4'd15
  } pg_op_e;

  // decoded strobes handed from control to the element chain
  typedef struct packed {
    logic       setI;
    logic       setD;
    logic       setDD;
    logic       periodic;
    logic       evalFix;
    logic       evalAny;
    logic [1:0] evalOrder;
    logic       skip;
    logic       mode;
    logic       refresh;
  } pg_strobe_t;

  typedef struct packed {
    logic                     valid;
    pg_strobe_t               stb;
    logic [ADDR_W-1:0]        x;
    logic [ADDR_W-1:0]        dx;
    logic [ADDR_W-1:0]        cnt;
    logic signed [VAL_W-1:0]  valI;
    logic signed [VAL_W-1:0]  valD;
    logic signed [VAL_W-1:0]  valDD;
  } pg_slot_t;

endpackage

// File: rtl/pixgen_ctrl.sv
module pixgen_ctrl
  import pixgen_pkg::*;
#(
  parameter int unsigned NUM_PE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdX,
  input  logic [ADDR_W-1:0] cmdDx,
  input  logic [VAL_W-1:0]  cmdI,
  input  logic [VAL_W-1:0]  cmdD,
  input  logic [VAL_W-1:0]  cmdDD,
  output logic              cmdReady,
  output pg_slot_t          entry
);

  localparam int unsigned FLIGHT_W = $clog2(NUM_PE + 1);
  localparam logic [FLIGHT_W-1:0] FLIGHT_LOAD = FLIGHT_W'(NUM_PE - 1);

  pg_op_e               op;
  pg_strobe_t           stb;
  logic                 accept;
  logic [1:0]           busyCnt;
  logic [FLIGHT_W-1:0]  flightCnt;

  assign op = pg_op_e'(cmdOp);

  always_comb begin
    stb = '0;
    case (op)
      OP_SET_I:    stb.setI = 1'b1;
      OP_SET_D:    stb.setD = 1'b1;
      OP_SET_DD:   stb.setDD = 1'b1;
      OP_SETP_I:   begin stb.setI = 1'b1;  stb.periodic = 1'b1; end
      OP_SETP_D:   begin stb.setD = 1'b1;  stb.periodic = 1'b1; end
      OP_SETP_DD:  begin stb.setDD = 1'b1; stb.periodic = 1'b1; end
      OP_EVAL_FIX: stb.evalFix = 1'b1;
      OP_EVAL_C:   begin stb.evalAny = 1'b1; stb.evalOrder = 2'd0; end
      OP_EVAL_L:   begin stb.evalAny = 1'b1; stb.evalOrder = 2'd1; end
      OP_EVAL_Q:   begin stb.evalAny = 1'b1; stb.evalOrder = 2'd2; end
      OP_SKIP:     stb.skip = 1'b1;
      OP_MODE:     stb.mode = 1'b1;
      OP_REFRESH:  stb.refresh = 1'b1;
      default:     stb = '0;
    endcase
  end

  assign cmdReady = (busyCnt == 2'd0) &&
                    !((op == OP_REFRESH) && (flightCnt != '0));
  assign accept   = cmdValid && cmdReady;

  always_comb begin
    entry       = '0;
    entry.valid = accept;
    entry.stb   = stb;
    entry.x     = cmdX;
    entry.dx    = cmdDx;
    entry.cnt   = '0;
    entry.valI  = cmdI;
    entry.valD  = cmdD;
    entry.valDD = cmdDD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt   <= 2'd0;
      flightCnt <= '0;
    end else begin
      if (accept && op == OP_EVAL_L)      busyCnt <= 2'd1;
      else if (accept && op == OP_EVAL_Q) busyCnt <= 2'd2;
      else if (busyCnt != 2'd0)           busyCnt <= busyCnt - 2'd1;

      if (accept && op == OP_REFRESH)     flightCnt <= FLIGHT_LOAD;
      else if (flightCnt != '0)           flightCnt <= flightCnt - 1'b1;
    end
  end

endmodule

// File: rtl/pixgen_pe.sv
module pixgen_pe
  import pixgen_pkg::*;
#(
  parameter int unsigned PE_IDX = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  pg_slot_t         inSlot,
  output pg_slot_t         nextSlot,
  output logic             pixHit,
  output logic [PIX_W-1:0] pixVal
);

  localparam logic [ADDR_W:0] POS = (ADDR_W + 1)'(PE_IDX);
  localparam int unsigned INT_HI = FRAC_W + PIX_W;

  logic [ADDR_W:0]         spanLo, spanHi;
  logic                    atX, pastX, inSpan, setHit;
  logic                    isEval, isFix, isSkip;
  logic signed [VAL_W-1:0] acc, preI, preD, preDD;
  logic signed [VAL_W-1:0] effI, effD, effDD, contrib;
  logic                    hasI, hasD, hasDD, frozen, skipMark, negEn;

  always_comb begin
    spanLo = {1'b0, inSlot.x};
    spanHi = spanLo + {1'b0, inSlot.dx};
    pastX  = POS >= spanLo;
    atX    = POS == spanLo;
    inSpan = pastX && (POS <= spanHi);
    setHit = inSlot.stb.periodic
           ? (pastX && (inSlot.cnt == '0) && (atX || inSlot.dx != '0))
           : atX;

    effI  = hasI  ? preI  : inSlot.valI;
    effD  = hasD  ? preD  : inSlot.valD;
    effDD = hasDD ? preDD : inSlot.valDD;
    contrib = (!negEn && effI[VAL_W-1]) ? '0 : effI;

    isEval = inSlot.valid && inSlot.stb.evalAny && inSpan;
    isFix  = inSlot.valid && inSlot.stb.evalFix && inSpan;
    isSkip = inSlot.valid && inSlot.stb.skip    && inSpan;

    nextSlot = inSlot;
    if (inSlot.valid && inSlot.stb.periodic && pastX)
      nextSlot.cnt = setHit ? inSlot.dx - 1'b1 : inSlot.cnt - 1'b1;
    if (isEval && inSlot.stb.evalOrder != 2'd0) begin
      nextSlot.valI  = effI + effD;
      nextSlot.valD  = (inSlot.stb.evalOrder == 2'd2) ? effD + effDD : effD;
      nextSlot.valDD = effDD;
    end

    pixHit = inSlot.valid && inSlot.stb.refresh;
    if (acc[VAL_W-1])                   pixVal = '0;
    else if (|acc[VAL_W-2:INT_HI])      pixVal = '1;
    else                                pixVal = acc[INT_HI-1:FRAC_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0; preI <= '0; preD <= '0; preDD <= '0;
      hasI <= 1'b0; hasD <= 1'b0; hasDD <= 1'b0;
      frozen <= 1'b0; skipMark <= 1'b0; negEn <= 1'b1;
    end else if (inSlot.valid) begin
      if (inSlot.stb.refresh) begin
        acc <= '0;
        hasI <= 1'b0; hasD <= 1'b0; hasDD <= 1'b0;
        frozen <= 1'b0; skipMark <= 1'b0;
      end
      if (inSlot.stb.mode) negEn <= inSlot.x[0];
      if (setHit) begin
        if (inSlot.stb.setI)  begin preI  <= inSlot.valI;  hasI  <= 1'b1; end
        if (inSlot.stb.setD)  begin preD  <= inSlot.valD;  hasD  <= 1'b1; end
        if (inSlot.stb.setDD) begin preDD <= inSlot.valDD; hasDD <= 1'b1; end
      end
      if (isSkip) skipMark <= 1'b1;
      if (isFix) begin
        if (skipMark)     skipMark <= 1'b0;
        else if (!frozen) begin acc <= inSlot.valI; frozen <= 1'b1; end
      end
      if (isEval) begin
        if (skipMark)     skipMark <= 1'b0;
        else if (!frozen) acc <= acc + contrib;
      end
    end
  end

endmodule

// File: rtl/pixgen_datapath.sv
module pixgen_datapath
  import pixgen_pkg::*;
#(
  parameter int unsigned NUM_PE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pg_slot_t          entry,
  output logic              pixValid,
  output logic [ADDR_W-1:0] pixAddr,
  output logic [PIX_W-1:0]  pixData
);

  pg_slot_t          stage [NUM_PE];
  pg_slot_t          fwd   [NUM_PE];
  logic [NUM_PE-1:0] hitVec;
  logic [PIX_W-1:0]  valArr [NUM_PE];
  logic              anyHit;
  logic [ADDR_W-1:0] selAddr;
  logic [PIX_W-1:0]  selVal;

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[k] <= '0;
        else       stage[k] <= entry;
      end
    end else begin : g_link
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[k] <= '0;
        else       stage[k] <= fwd[k-1];
      end
    end

    pixgen_pe #(.PE_IDX(k)) u_pe (
      .clk      (clk),
      .rstN     (rstN),
      .inSlot   (stage[k]),
      .nextSlot (fwd[k]),
      .pixHit   (hitVec[k]),
      .pixVal   (valArr[k])
    );
  end

  // at most one refresh is in the chain, so the hits are one-hot
  always_comb begin
    anyHit  = |hitVec;
    selAddr = '0;
    selVal  = '0;
    for (int k = 0; k < NUM_PE; k++) begin
      if (hitVec[k]) begin
        selAddr = selAddr | ADDR_W'(k);
        selVal  = selVal  | valArr[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      pixAddr  <= '0;
      pixData  <= '0;
    end else begin
      pixValid <= anyHit;
      pixAddr  <= selAddr;
      pixData  <= selVal;
    end
  end

endmodule

// File: rtl/pixgen_array.sv
module pixgen_array
  import pixgen_pkg::*;
#(
  parameter int unsigned NUM_PE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdX,
  input  logic [ADDR_W-1:0] cmdDx,
  input  logic [VAL_W-1:0]  cmdI,
  input  logic [VAL_W-1:0]  cmdD,
  input  logic [VAL_W-1:0]  cmdDD,
  output logic              cmdReady,
  output logic              pixValid,
  output logic [ADDR_W-1:0] pixAddr,
  output logic [PIX_W-1:0]  pixData
);

  pg_slot_t entry;

  pixgen_ctrl #(.NUM_PE(NUM_PE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdX     (cmdX),
    .cmdDx    (cmdDx),
    .cmdI     (cmdI),
    .cmdD     (cmdD),
    .cmdDD    (cmdDD),
    .cmdReady (cmdReady),
    .entry    (entry)
  );

  pixgen_datapath #(.NUM_PE(NUM_PE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .entry    (entry),
    .pixValid (pixValid),
    .pixAddr  (pixAddr),
    .pixData  (pixData)
  );

endmodule

// File: rtl/pixgen_array_chk.sv
module pixgen_array_chk
  import pixgen_pkg::*;
#(
  parameter int unsigned NUM_PE = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [3:0]        cmdOp,
  input logic [ADDR_W-1:0] cmdX,
  input logic [ADDR_W-1:0] cmdDx,
  input logic [VAL_W-1:0]  cmdI,
  input logic [VAL_W-1:0]  cmdD,
  input logic [VAL_W-1:0]  cmdDD,
  input logic              cmdReady,
  input logic              pixValid,
  input logic [ADDR_W-1:0] pixAddr,
  input logic [PIX_W-1:0]  pixData
);

  logic taken;
  assign taken = cmdValid && cmdReady;

  a_r12_linear_stall: assert property (@(posedge clk) disable iff (!rstN)
    (taken && cmdOp == 4'd9) |=> !cmdReady);

  a_r12_quad_stall: assert property (@(posedge clk) disable iff (!rstN)
    (taken && cmdOp == 4'd10) |=> !cmdReady ##1 !cmdReady);

  a_r12_refresh_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (taken && cmdOp == 4'd13) |=> !(cmdReady && cmdOp == 4'd13));

  a_r2_first_pixel: assert property (@(posedge clk) disable iff (!rstN)
    (taken && cmdOp == 4'd13) |=> ##1 (pixValid && pixAddr == '0));

  a_r2_addr_order: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(pixValid)) |->
      (pixAddr == '0 || pixAddr == ADDR_W'($past(pixAddr) + 1'b1)));

  a_r2_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (pixAddr < ADDR_W'(NUM_PE)));

endmodule

bind pixgen_array pixgen_array_chk #(.NUM_PE(NUM_PE)) u_chk (.*);

// File: tb/test_pixgen_array.sv
module test_pixgen_array;

  localparam int NPE = 8;
  localparam int NV  = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdOp = 4'd0;
  logic [11:0] cmdX = '0, cmdDx = '0;
  logic [35:0] cmdI = '0, cmdD = '0, cmdDD = '0;
  logic        cmdReady, pixValid;
  logic [11:0] pixAddr, pixData;

  int nChecks = 0, nFail = 0, cyc = 0, lastAcc = 0;
  int gotPix [NPE];
  int gotCyc [NPE];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pixgen_array i_pixgen_array (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdX(cmdX), .cmdDx(cmdDx), .cmdI(cmdI), .cmdD(cmdD), .cmdDD(cmdDD),
    .cmdReady(cmdReady), .pixValid(pixValid), .pixAddr(pixAddr),
    .pixData(pixData)
  );

  always @(negedge clk) begin
    if (pixValid && pixAddr < 12'(NPE)) begin
      gotPix[pixAddr] = int'(pixData);
      gotCyc[pixAddr] = cyc;
    end
  end

  // {opA,xA,dxA,iA,dA,ddA, opB,xB,dxB,iB,dB,ddB}, values in whole units
  localparam int VEC [NV][12] = '{
    '{ 8,2,3,5,0,0,       8,4,10,3,0,0 },
    '{ 9,1,4,10,3,0,      15,0,0,0,0,0 },
    '{ 10,0,7,1,1,2,      0,0,0,0,0,0 },
    '{ 8,0,1,5000,0,0,    8,3,0,-7,0,0 },
    '{ 1,3,0,100,0,0,     9,1,4,10,2,0 },
    '{ 4,1,3,50,0,0,      8,0,7,2,0,0 },
    '{ 7,2,1,9,0,0,       8,0,7,1,0,0 },
    '{ 11,5,2,0,0,0,      8,0,7,4,0,0 },
    '{ 5,0,4,0,10,0,      9,0,7,1,1,0 }
  };
  localparam int EXP [NV][NPE] = '{
    '{ 0,0,5,5,8,8,3,3 },
    '{ 0,10,13,16,19,22,0,0 },
    '{ 1,2,5,10,17,26,37,50 },
    '{ 4095,4095,0,0,0,0,0,0 },
    '{ 0,10,12,100,102,104,0,0 },
    '{ 2,50,2,2,50,2,2,50 },
    '{ 1,1,9,9,1,1,1,1 },
    '{ 4,4,4,4,4,0,0,0 },
    '{ 1,11,21,31,41,51,61,71 }
  };
  string vTag [NV] = '{"R3", "R4 R13", "R5 R13", "R11", "R6", "R7", "R8",
                       "R9", "R7"};

  function automatic logic [35:0] fx(input int v);
    return 36'(longint'(v) <<< 20);
  endfunction

  task automatic chk(input string req, input int act, input int exp,
                     input string what);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sendCmd(input int op, input int x, input int dx,
                         input logic [35:0] vi, input logic [35:0] vd,
                         input logic [35:0] vdd);
    @(negedge clk);
    cmdOp = 4'(op); cmdX = 12'(x); cmdDx = 12'(dx);
    cmdI = vi; cmdD = vd; cmdDD = vdd; cmdValid = 1'b1;
    #1;
    while (!cmdReady) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 4'd0; lastAcc = cyc;
  endtask

  task automatic refreshCheck(input string req, input int e [NPE]);
    for (int k = 0; k < NPE; k++) gotPix[k] = -1;
    sendCmd(13, 0, 0, '0, '0, '0);
    repeat (NPE + 1) @(negedge clk);
    for (int k = 0; k < NPE; k++)
      chk(req, gotPix[k], e[k], $sformatf("pixel %0d", k));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R2 watchdog: actual hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int zeros [NPE];
    int e [NPE];
    int lows;
    int c0;
    for (int k = 0; k < NPE; k++) zeros[k] = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", int'(pixValid), 0, "pixValid in reset");
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1", int'(cmdReady), 1, "cmdReady after reset");
    chk("R1", int'(pixValid), 0, "pixValid after reset");

    // R1/R2: first refresh gives zeros, element k appears k+1 edges later
    refreshCheck("R1", zeros);
    c0 = lastAcc;
    for (int k = 0; k < NPE; k++)
      chk("R2", gotCyc[k] - c0, k + 1, $sformatf("latency of pixel %0d", k));

    // scanline vectors
    for (int v = 0; v < NV; v++) begin
      sendCmd(VEC[v][0], VEC[v][1], VEC[v][2],
              fx(VEC[v][3]), fx(VEC[v][4]), fx(VEC[v][5]));
      sendCmd(VEC[v][6], VEC[v][7], VEC[v][8],
              fx(VEC[v][9]), fx(VEC[v][10]), fx(VEC[v][11]));
      for (int k = 0; k < NPE; k++) e[k] = EXP[v][k];
      refreshCheck(vTag[v], e);
    end

    // R2: state cleared by the refresh before
    refreshCheck("R2", zeros);

    // R10: negatives ignored, then summed again
    sendCmd(12, 0, 0, '0, '0, '0);
    sendCmd(8, 0, 7, fx(10), '0, '0);
    sendCmd(8, 0, 3, fx(-4), '0, '0);
    for (int k = 0; k < NPE; k++) e[k] = 10;
    refreshCheck("R10", e);
    sendCmd(12, 1, 0, '0, '0, '0);
    sendCmd(8, 0, 7, fx(10), '0, '0);
    sendCmd(8, 0, 3, fx(-4), '0, '0);
    for (int k = 0; k < NPE; k++) e[k] = (k < 4) ? 6 : 10;
    refreshCheck("R10", e);

    // R9: skip swallows only the next evaluate
    sendCmd(11, 0, 7, '0, '0, '0);
    sendCmd(8, 0, 7, fx(3), '0, '0);
    sendCmd(8, 0, 7, fx(2), '0, '0);
    for (int k = 0; k < NPE; k++) e[k] = 2;
    refreshCheck("R9", e);

    // R8: a frozen pixel ignores a second fix and a constant evaluate
    sendCmd(7, 0, 0, fx(9), '0, '0);
    sendCmd(7, 0, 0, fx(3), '0, '0);
    sendCmd(8, 0, 7, fx(1), '0, '0);
    for (int k = 0; k < NPE; k++) e[k] = (k == 0) ? 9 : 1;
    refreshCheck("R8", e);

    // R11: half-unit slope, fraction truncated
    sendCmd(9, 0, 7, '0, 36'(1) << 19, '0);
    for (int k = 0; k < NPE; k++) e[k] = k / 2;
    refreshCheck("R11", e);

    // R12: issue stalls
    @(negedge clk);
    cmdOp = 4'd10; cmdX = '0; cmdDx = '0; cmdI = '0; cmdD = '0; cmdDD = '0;
    cmdValid = 1'b1; #1;
    chk("R12", int'(cmdReady), 1, "ready before quadratic");
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0; cmdOp = 4'd0; #1;
    chk("R12", int'(cmdReady), 0, "quadratic stall cycle 1");
    @(negedge clk); #1;
    chk("R12", int'(cmdReady), 0, "quadratic stall cycle 2");
    @(negedge clk); #1;
    chk("R12", int'(cmdReady), 1, "ready after quadratic");
    cmdOp = 4'd9; cmdValid = 1'b1; #1;
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0; cmdOp = 4'd0; #1;
    chk("R12", int'(cmdReady), 0, "linear stall cycle 1");
    @(negedge clk); #1;
    chk("R12", int'(cmdReady), 1, "ready after linear");
    cmdOp = 4'd13; cmdValid = 1'b1; #1;
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0; #1;
    lows = 0;
    while (!cmdReady && lows < 20) begin
      lows++;
      @(negedge clk); #1;
    end
    chk("R12", lows, NPE - 1, "refresh hold-off cycles");
    cmdOp = 4'd0;
    repeat (NPE + 2) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule